// File: doc/BRIEF.md
# Instruction Cycle Sequencer

This block is the control sequencer of a small accumulator machine whose instructions are 16 bits wide. Each instruction passes through a set of sub-cycles: fetch/decode, optionally an indirect pointer read, optionally a direct operand read, a hand-off to an external execute unit, and, when an interrupt is pending, a fixed interrupt service cycle. A three-bit cycle register names the current sub-cycle. A two-bit timing counter provides four timing slots, T0 to T3, inside each sub-cycle. The block owns the program counter, the memory address and buffer registers, the operand address register, the opcode register and the mode register. It drives a 1K-word memory port with separate read and write strobes.

The instruction word holds the mode in bits 15:14, the opcode in bits 13:10 and a 10-bit address or data field in bits 9:0. The memory reads synchronously: the read strobe is raised in one slot and the data is taken in the following slot. There are no back-pressure rules, because the memory port and the execute hand-off are plain strobes with fixed timing. The execute unit sees `exec_start` and answers with a one-cycle `exec_done` pulse. A pending interrupt makes the sequencer save the return address in word 0 and carry on from word 1. A halt request parks the sequencer in fetch T0 until reset.

Top module: `instr_cycle_seq`

## Requirements
- R1: During and directly after reset, the cycle code is fetch (000), the timing slot is T0, PC is 0, and neither memory strobe is active.
- R2: In the fetch, indirect and interrupt sub-cycles, the timing slot moves up by one on every clock, from T0 through T3, and then wraps to T0.
- R3: Fetch works as follows. In T0, MAR takes PC. In T1, the read strobe is raised at address PC and PC increments. In T2, the word read is captured into MBR, bits 15:14 into the mode register, bits 13:10 into OPR and bits 9:0 into AR. These values are visible from T3.
- R4: At fetch T3 the next sub-cycle is chosen. Mode 01 selects direct (010). Mode 11 with an opcode other than 1111 selects indirect (001). Every other word selects execute (011).
- R5: Indirect reads the word at AR, replaces AR with bits 9:0 of that word, and continues into direct after T3. Execute T0 is therefore reached 7 clocks after the fetch T3 slot.
- R6: Direct reads the operand at AR into MBR and goes from T2 straight to execute T0 without spending T3. Execute T0 is therefore reached 3 clocks after the fetch T3 slot.
- R7: `exec_start` is high exactly in execute T0. While no `exec_done` arrives, the sequencer stays in execute and the timing slot advances to T3 and holds there.
- R8: A cycle with `exec_done` high in execute ends execute. The next cycle is interrupt (100) at T0 if `int_req` is high, and fetch T0 otherwise.
- R9: Interrupt works as follows. In T0, `int_ack` pulses and MBR takes PC. In T1, MAR and PC become 0. In T2, the write strobe stores MBR at address 0 and PC becomes 1. After T3, fetch resumes at address 1.
- R10: After `halt` has been seen high, the sequencer stops on reaching fetch T0. It then holds its cycle, slot and PC, and raises no strobe, until reset.
- R11: The read and write strobes are never active in the same cycle, and `mem_wdata` always shows MBR.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| halt | input | 1 | Halt request, latched until reset |
| int_req | input | 1 | Interrupt flip-flop state from outside |
| exec_done | input | 1 | One-cycle completion pulse from the execute unit |
| mem_rdata | input | 16 | Read data, valid one cycle after the read strobe |
| mem_addr | output | 10 | Memory address (MAR) |
| mem_rd | output | 1 | Read strobe |
| mem_wr | output | 1 | Write strobe |
| mem_wdata | output | 16 | Write data (MBR) |
| exec_start | output | 1 | High in execute T0 |
| int_ack | output | 1 | Clears the interrupt flip-flop (interrupt T0) |
| cycle_id | output | 3 | Current sub-cycle code |
| tstate | output | 2 | Current timing slot (0 to 3) |
| pc | output | 10 | Program counter |
| ar | output | 10 | Operand address register |
| opr | output | 4 | Opcode register |
| mode | output | 2 | Addressing mode register |
| mbr | output | 16 | Memory buffer register |

## Verification
The embedded properties check, on every cycle, the following local rules: the timing slot steps by one unless it is cleared or held, direct never occupies T3, execute holds at T3 while it waits, PC increments after fetch T1, a halted sequencer stays frozen, writes go only to address 0, and the two strobes are exclusive. Other behaviour can only be shown by the bench's scenarios, because it spans a whole instruction: the clock count from dispatch to execute for each mode, that the right word lands in AR and MBR through a pointer, the interrupt's saved return address in memory together with the resumption at word 1, and halting at an instruction boundary.

// File: rtl/icseq_pkg.sv
package icseq_pkg;
  typedef enum logic [2:0] {
    CYC_FETCH = 3'b000,
    CYC_IND   = 3'b001,
    CYC_DIR   = 3'b010,
    CYC_EXEC  = 3'b011,
    CYC_INTR  = 3'b100
  } cyc_e;

  localparam int TW = 2;
  localparam logic [TW-1:0] SLOT0 = 2'd0;
  localparam logic [TW-1:0] SLOT1 = 2'd1;
  localparam logic [TW-1:0] SLOT2 = 2'd2;
  localparam logic [TW-1:0] SLOT3 = 2'd3;
endpackage

// File: rtl/icseq_timer.sv
module icseq_timer
  import icseq_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          hold,
  output logic [TW-1:0] slot
);
  always_ff @(posedge clk) begin
    if (!rst_n)    slot <= SLOT0;
    else if (clr)  slot <= SLOT0;
    else if (!hold) slot <= slot + TW'(1);
  end

  // Free-running step unless cleared or held (R2)
  assert_slot_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !hold) |=> slot == TW'($past(slot) + TW'(1)));
endmodule

// File: rtl/icseq_cycle_fsm.sv
module icseq_cycle_fsm
  import icseq_pkg::*;
#(
  parameter int OPW = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [TW-1:0]  slot,
  input  logic [1:0]     mode,
  input  logic [OPW-1:0] opr,
  input  logic           exec_done,
  input  logic           int_req,
  input  logic           frozen,
  output cyc_e           cyc,
  output logic           slot_clr,
  output logic           slot_hold
);
  cyc_e nxt;
  logic reg_or_io;

  assign reg_or_io = &opr;

  always_comb begin
    nxt       = cyc;
    slot_clr  = 1'b0;
    slot_hold = 1'b0;
    if (frozen) begin
      slot_hold = 1'b1;
    end else begin
      unique case (cyc)
        CYC_FETCH: if (slot == SLOT3) begin
          if (mode == 2'b01)                     nxt = CYC_DIR;
          else if (mode == 2'b11 && !reg_or_io)  nxt = CYC_IND;
          else                                   nxt = CYC_EXEC;
        end
        CYC_IND:  if (slot == SLOT3) nxt = CYC_DIR;
        CYC_DIR:  if (slot == SLOT2) begin
          nxt      = CYC_EXEC;
          slot_clr = 1'b1;
        end
        CYC_EXEC: begin
          if (exec_done) begin
            nxt      = int_req ? CYC_INTR : CYC_FETCH;
            slot_clr = 1'b1;
          end else if (slot == SLOT3) begin
            slot_hold = 1'b1;
          end
        end
        CYC_INTR: if (slot == SLOT3) nxt = CYC_FETCH;
        default: begin
          nxt      = CYC_FETCH;
          slot_clr = 1'b1;
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) cyc <= CYC_FETCH;
    else        cyc <= nxt;
  end

  // Direct cuts short at T2 (R6)
  assert_dir_no_t3_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cyc == CYC_DIR |-> slot != SLOT3);
  // Execute parks at T3 while waiting (R7)
  assert_exec_wait_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc == CYC_EXEC && slot == SLOT3 && !exec_done) |=> (cyc == CYC_EXEC && slot == SLOT3));
endmodule

// File: rtl/icseq_datapath.sv
module icseq_datapath
  import icseq_pkg::*;
#(
  parameter int AW  = 10,
  parameter int OPW = 4,
  localparam int DW = 2 + OPW + AW
) (
  input  logic           clk,
  input  logic           rst_n,
  input  cyc_e           cyc,
  input  logic [TW-1:0]  slot,
  input  logic           frozen,
  input  logic [DW-1:0]  mem_rdata,
  output logic [AW-1:0]  mar,
  output logic [AW-1:0]  pc,
  output logic [AW-1:0]  ar,
  output logic [OPW-1:0] opr,
  output logic [1:0]     mode,
  output logic [DW-1:0]  mbr,
  output logic           mem_rd,
  output logic           mem_wr,
  output logic           int_ack
);
  localparam int OP_LSB   = AW;
  localparam int MODE_LSB = AW + OPW;

  always_comb begin
    mem_rd  = 1'b0;
    mem_wr  = 1'b0;
    int_ack = 1'b0;
    if (!frozen) begin
      unique case (cyc)
        CYC_FETCH, CYC_IND, CYC_DIR: mem_rd = (slot == SLOT1);
        CYC_INTR: begin
          int_ack = (slot == SLOT0);
          mem_wr  = (slot == SLOT2);
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mar  <= '0;
      pc   <= '0;
      ar   <= '0;
      opr  <= '0;
      mode <= '0;
      mbr  <= '0;
    end else if (!frozen) begin
      unique case (cyc)
        CYC_FETCH: begin
          if (slot == SLOT0) mar <= pc;
          if (slot == SLOT1) pc  <= pc + AW'(1);
          if (slot == SLOT2) begin
            mbr  <= mem_rdata;
            mode <= mem_rdata[MODE_LSB +: 2];
            opr  <= mem_rdata[OP_LSB +: OPW];
            ar   <= mem_rdata[AW-1:0];
          end
        end
        CYC_IND: begin
          if (slot == SLOT0) mar <= ar;
          if (slot == SLOT2) begin
            mbr <= mem_rdata;
            ar  <= mem_rdata[AW-1:0];
          end
        end
        CYC_DIR: begin
          if (slot == SLOT0) mar <= ar;
          if (slot == SLOT2) mbr <= mem_rdata;
        end
        CYC_INTR: begin
          if (slot == SLOT0) mbr <= {{(DW-AW){1'b0}}, pc};
          if (slot == SLOT1) begin
            mar <= '0;
            pc  <= '0;
          end
          if (slot == SLOT2) pc <= pc + AW'(1);
        end
        default: ;
      endcase
    end
  end

  // PC moves on right after the fetch read slot (R3)
  assert_pc_bump_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc == CYC_FETCH && slot == SLOT1 && !frozen) |=> pc == AW'($past(pc) + AW'(1)));
  // Writes only target the return-address word (R9)
  assert_wr_at_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |-> (mar == '0 && cyc == CYC_INTR));
  // Strobes are exclusive (R11)
  assert_strobe_excl_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({mem_rd, mem_wr}));
endmodule

// File: rtl/instr_cycle_seq.sv
module instr_cycle_seq
  import icseq_pkg::*;
#(
  parameter int AW  = 10,
  parameter int OPW = 4,
  localparam int DW = 2 + OPW + AW
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           halt,
  input  logic           int_req,
  input  logic           exec_done,
  input  logic [DW-1:0]  mem_rdata,
  output logic [AW-1:0]  mem_addr,
  output logic           mem_rd,
  output logic           mem_wr,
  output logic [DW-1:0]  mem_wdata,
  output logic           exec_start,
  output logic           int_ack,
  output logic [2:0]     cycle_id,
  output logic [TW-1:0]  tstate,
  output logic [AW-1:0]  pc,
  output logic [AW-1:0]  ar,
  output logic [OPW-1:0] opr,
  output logic [1:0]     mode,
  output logic [DW-1:0]  mbr
);
  cyc_e          cyc;
  logic [TW-1:0] slot;
  logic          slot_clr, slot_hold;
  logic          halted_q, frozen;
  logic [AW-1:0] mar;

  always_ff @(posedge clk) begin
    if (!rst_n)    halted_q <= 1'b0;
    else if (halt) halted_q <= 1'b1;
  end

  assign frozen = halted_q && (cyc == CYC_FETCH) && (slot == SLOT0);

  icseq_timer u_timer (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (slot_clr),
    .hold (slot_hold),
    .slot (slot)
  );

  icseq_cycle_fsm #(.OPW(OPW)) u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .slot     (slot),
    .mode     (mode),
    .opr      (opr),
    .exec_done(exec_done),
    .int_req  (int_req),
    .frozen   (frozen),
    .cyc      (cyc),
    .slot_clr (slot_clr),
    .slot_hold(slot_hold)
  );

  icseq_datapath #(.AW(AW), .OPW(OPW)) u_dp (
    .clk      (clk),
    .rst_n    (rst_n),
    .cyc      (cyc),
    .slot     (slot),
    .frozen   (frozen),
    .mem_rdata(mem_rdata),
    .mar      (mar),
    .pc       (pc),
    .ar       (ar),
    .opr      (opr),
    .mode     (mode),
    .mbr      (mbr),
    .mem_rd   (mem_rd),
    .mem_wr   (mem_wr),
    .int_ack  (int_ack)
  );

  assign mem_addr   = mar;
  assign mem_wdata  = mbr;
  assign cycle_id   = cyc;
  assign tstate     = slot;
  assign exec_start = (cyc == CYC_EXEC) && (slot == SLOT0);

  // Parked sequencer stays put (R10)
  assert_halt_park_R10: assert property (@(posedge clk) disable iff (!rst_n)
    frozen |=> (cyc == CYC_FETCH && slot == SLOT0 && $stable(pc) && !mem_rd && !mem_wr));
endmodule

// File: tb/instr_cycle_seq_bench.sv
`timescale 1ns/1ps
module instr_cycle_seq_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        halt = 1'b0;
  logic        int_req = 1'b0;
  logic        exec_done = 1'b0;
  logic [15:0] mem_rdata;
  logic [9:0]  mem_addr;
  logic        mem_rd, mem_wr;
  logic [15:0] mem_wdata;
  logic        exec_start, int_ack;
  logic [2:0]  cycle_id;
  logic [1:0]  tstate;
  logic [9:0]  pc, ar;
  logic [3:0]  opr;
  logic [1:0]  mode;
  logic [15:0] mbr;

  int tests = 0;
  int fails = 0;
  bit finished = 1'b0;

  logic [15:0] mem [0:1023];

  always #2.5 clk = ~clk;

  always_ff @(posedge clk) begin
    if (mem_rd) mem_rdata <= mem[mem_addr];
    if (mem_wr) mem[mem_addr] <= mem_wdata;
  end

  instr_cycle_seq u_instr_cycle_seq (
    .clk(clk), .rst_n(rst_n), .halt(halt), .int_req(int_req), .exec_done(exec_done),
    .mem_rdata(mem_rdata), .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .mem_wdata(mem_wdata), .exec_start(exec_start), .int_ack(int_ack),
    .cycle_id(cycle_id), .tstate(tstate), .pc(pc), .ar(ar), .opr(opr),
    .mode(mode), .mbr(mbr)
  );

  // {word, expected dispatch cycle, AR at execute, MBR at execute}
  localparam logic [44:0] VEC [6] = '{
    {16'h0005, 3'b011, 10'd5,   16'h0005},
    {16'h40C8, 3'b010, 10'd200, 16'hBEEF},
    {16'hCD2C, 3'b001, 10'd201, 16'h1234},
    {16'hFC04, 3'b011, 10'd4,   16'hFC04},
    {16'h8807, 3'b011, 10'd7,   16'h8807},
    {16'h3C01, 3'b011, 10'd1,   16'h3C01}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic run_insn(input logic [15:0] word, input logic [2:0] expc,
                          input logic [9:0] expar, input logic [15:0] expmbr,
                          input logic [9:0] addr, input int stall, input bit irq);
    int lat;
    int n;
    chk("R3 fetch T0 pc", {22'd0, pc}, {22'd0, addr});
    chk("R2 fetch T0 slot", {30'd0, tstate}, 32'd0);
    step();
    chk("R3 fetch T1 read", {21'd0, mem_rd, mem_addr}, {21'd0, 1'b1, addr});
    chk("R2 fetch T1 slot", {30'd0, tstate}, 32'd1);
    step();
    chk("R3 fetch T2 pc+1", {22'd0, pc}, {22'd0, 10'(addr + 10'd1)});
    step();
    chk("R3 fetch T3 fields", {mbr, mode, opr, ar}, {word, word[15:14], word[13:10], word[9:0]});
    step();
    chk("R4 dispatch", {29'd0, cycle_id}, {29'd0, expc});
    lat = (expc == 3'b001) ? 7 : (expc == 3'b010) ? 3 : 0;
    n = 0;
    while (!(cycle_id == 3'b011 && tstate == 2'd0) && n < 12) begin
      step();
      n++;
    end
    if (expc == 3'b001) chk("R5 indirect latency", n, lat);
    else if (expc == 3'b010) chk("R6 direct latency", n, lat);
    else chk("R4 exec latency", n, lat);
    chk("R7 exec_start", {31'd0, exec_start}, 32'd1);
    chk("R5 R6 operand", {6'd0, ar, mbr}, {6'd0, expar, expmbr});
    for (int k = 0; k < stall; k++) step();
    if (stall > 0) begin
      chk("R7 exec parked", {27'd0, exec_start, cycle_id, tstate}, {27'd0, 1'b0, 3'b011, 2'd3});
    end
    exec_done = 1'b1;
    int_req = irq;
    step();
    exec_done = 1'b0;
    int_req = 1'b0;
    chk("R8 after execute", {27'd0, cycle_id, tstate}, {27'd0, irq ? 3'b100 : 3'b000, 2'd0});
  endtask

  initial begin
    for (int i = 0; i < 1024; i++) mem[i] = 16'h0000;
    for (int i = 0; i < 6; i++) mem[i] = VEC[i][44:29];
    mem[6]   = 16'h0403;
    mem[200] = 16'hBEEF;
    mem[201] = 16'h1234;
    mem[300] = 16'h00C9;

    repeat (3) @(negedge clk);
    chk("R1 reset state", {15'd0, cycle_id, tstate, pc, mem_rd, mem_wr}, 32'd0);
    rst_n = 1'b1;
    chk("R1 after release", {15'd0, cycle_id, tstate, pc, mem_rd, mem_wr}, 32'd0);

    for (int i = 0; i < 6; i++) begin
      run_insn(VEC[i][44:29], VEC[i][28:26], VEC[i][25:16], VEC[i][15:0], 10'(i), 0, 1'b0);
    end

    // Execute waiting, then interrupt service (R7, R8, R9)
    run_insn(16'h0403, 3'b011, 10'd3, 16'h0403, 10'd6, 5, 1'b1);
    chk("R9 int_ack T0", {31'd0, int_ack}, 32'd1);
    step();
    chk("R9 T1 mbr holds pc", {16'd0, mbr}, 32'd7);
    chk("R2 intr slot", {30'd0, tstate}, 32'd1);
    step();
    chk("R9 T2 write", {5'd0, mem_wr, mem_rd, mem_addr, mem_wdata}, {5'd0, 1'b1, 1'b0, 10'd0, 16'd7});
    chk("R11 wdata is mbr", {16'd0, mem_wdata}, {16'd0, mbr});
    step();
    chk("R9 T3 pc one", {22'd0, pc}, 32'd1);
    chk("R9 saved word", {16'd0, mem[0]}, 32'd7);
    step();
    chk("R9 resume fetch", {19'd0, cycle_id, tstate, 1'b0, pc} , {19'd0, 3'b000, 2'd0, 1'b0, 10'd1});

    // Halt latched mid-instruction, park at next boundary (R10)
    halt = 1'b1;
    step();
    halt = 1'b0;
    chk("R10 runs to boundary", {30'd0, tstate}, 32'd1);
    step(); step(); step();
    n_skip_to_exec();
    chk("R10 parked", {16'd0, cycle_id, tstate, pc, mem_rd}, {16'd0, 3'b000, 2'd0, 10'd2, 1'b0});
    step(); step(); step(); step();
    chk("R10 still parked", {15'd0, cycle_id, tstate, pc, mem_rd, mem_wr}, {15'd0, 3'b000, 2'd0, 10'd2, 2'b00});

    rst_n = 1'b0;
    step();
    chk("R1 reset again", {15'd0, cycle_id, tstate, pc, mem_rd, mem_wr}, 32'd0);
    rst_n = 1'b1;
    step();
    chk("R10 reset clears halt", {30'd0, tstate}, 32'd1);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  // Continue the direct instruction at word 1 from fetch T0 of its dispatch.
  task automatic n_skip_to_exec();
    int n;
    n = 0;
    while (!(cycle_id == 3'b011 && tstate == 2'd0) && n < 12) begin
      step();
      n++;
    end
    chk("R6 reached execute", {29'd0, cycle_id}, 32'd3);
    chk("R6 operand under halt", {16'd0, mbr}, 32'hBEEF);
    exec_done = 1'b1;
    step();
    exec_done = 1'b0;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      fails++;
      tests++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule